// File: doc/BRIEF.md
# Transmit Stream Protocol Compliance Monitor

This block watches a transmit-side packet stream that uses a ready/valid handshake with start-of-packet, end-of-packet, an empty-lane count, an error (nullify) strobe, and per-packet type information. It never drives the stream. It checks that the source follows the backpressure timing and the nullification rules. Each class of breach has its own event bit. The block raises that bit as a one-cycle pulse and also keeps it in a sticky status bit. It can sit beside a stream in simulation or stay in silicon as a permanent monitor.

The monitor keeps short histories of ready, valid and the error strobe. It tracks whether a packet is open and how many beats it has accepted. At each packet start it latches the posted and payload flags. A write-one-to-clear input clears the sticky bits.

Top module: `txs_compliance_mon`

## Requirements
- R1: While reset is asserted and right after it is released, all pulse and sticky bits are 0 and no packet is open.
- R2: Bit 0 (drop) flags the following case: a packet is open, valid falls from 1 to 0, and ready was high in both of the two preceding cycles.
- R3: Bit 1 (late stop) flags any cycle where valid is high while ready is low in that cycle and in the two cycles before it.
- R4: Bit 2 (stall) flags the following case: a packet is open, valid is low in this cycle and the previous one, and ready is high in this cycle and the two before it.
- R5: Bit 3 (empty) flags any valid beat that carries a nonzero 2-bit empty field without end-of-packet.
- R6: Bit 4 (error placement) flags an error strobe under any of these conditions: without valid, on a start beat, on an end beat, or in the cycle right after another error strobe.
- R7: Bit 5 (error use) flags an accepted end beat of a packet that saw an error strobe, when that packet is not posted/completion, or carries no payload, or is 1 or 2 beats long.
- R8: Bit 6 (gap) flags a start-of-packet with valid in the cycle right after the accepted end beat of a nullified packet. A start one or more idle cycles later is not flagged.
- R9: Bit 7 (framing) flags an accepted start beat while a packet is already open, and an accepted end beat (without start) while no packet is open. A beat is accepted when valid and ready are both high.
- R10: A breach seen in cycle t gives a one-cycle pulse and sets its sticky bit, both visible after the edge that ends cycle t. A clear bit sampled at an edge clears its sticky bit. A new breach in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_i | input | 1 | Sink ready as seen on the stream |
| valid_i | input | 1 | Source valid |
| sop_i | input | 1 | Start of packet |
| eop_i | input | 1 | End of packet |
| empty_i | input | 2 | Number of empty upper 64-bit lanes on the end beat |
| err_i | input | 1 | Nullify strobe |
| posted_i | input | 1 | Packet is posted or a completion (sampled on start beat) |
| payload_i | input | 1 | Packet carries payload (sampled on start beat) |
| clr_i | input | 8 | Write-one-to-clear for sticky bits |
| pulse_o | output | 8 | One-cycle breach events, one bit per class |
| sticky_o | output | 8 | Sticky breach status, one bit per class |

## Verification
The hardest conditions to reach are the backpressure windows. These need ready held low for several cycles while valid trails it by an exact count. After that, ready must come back while valid returns after a chosen delay, all inside an open packet. The stimulus sweeps every combination of fall delay (0 to 4 cycles) and reassert delay (0 to 4 cycles) inside one packet. The expected pulse for each cycle is worked out from the two window rules. Directed packets then cover the empty field, the placement and legality of the error strobe, the gap after a nullified packet, and framing. Sticky clear and set-over-clear are covered as well.

// File: rtl/txm_pkg.sv
`timescale 1ns/1ps
package txm_pkg;
  localparam int unsigned NCLS = 8;

  typedef enum int unsigned {
    V_DROP    = 0,
    V_LATE    = 1,
    V_STALL   = 2,
    V_EMPTY   = 3,
    V_ERRPOS  = 4,
    V_ERRUSE  = 5,
    V_NULLGAP = 6,
    V_FRAME   = 7
  } viol_e;

  typedef logic [NCLS-1:0] viol_vec_t;
endpackage

// File: rtl/txm_hist.sv
`timescale 1ns/1ps
module txm_hist #(
  parameter int unsigned RLAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ready_i,
  input  logic            valid_i,
  input  logic            err_i,
  output logic [RLAT-1:0] rd_hist_o,
  output logic            valid_d1_o,
  output logic            err_d1_o
);
  logic [RLAT-1:0] rd_q, rd_n;
  logic            vld_q, vld_n;
  logic            err_q, err_n;

  generate
    if (RLAT == 1) begin : g_one
      assign rd_n = ready_i;
    end else begin : g_many
      assign rd_n = {rd_q[RLAT-2:0], ready_i};
    end
  endgenerate

  always_comb begin
    vld_n = valid_i;
    err_n = err_i;
  end

  // ready history resets high so that no window opens at time zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '1;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      rd_q  <= rd_n;
      vld_q <= vld_n;
      err_q <= err_n;
    end
  end

  assign rd_hist_o  = rd_q;
  assign valid_d1_o = vld_q;
  assign err_d1_o   = err_q;
endmodule

// File: rtl/txm_frame.sv
`timescale 1ns/1ps
module txm_frame #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_i,
  input  logic valid_i,
  input  logic sop_i,
  input  logic eop_i,
  input  logic err_i,
  input  logic posted_i,
  input  logic payload_i,
  output logic in_pkt_o,
  output logic v_erruse_o,
  output logic v_gap_o,
  output logic v_frame_o
);
  localparam logic [CNT_W-1:0] SHORT_MAX = CNT_W'(2);

  logic             in_pkt_q, in_pkt_n;
  logic [CNT_W-1:0] beats_q, beats_n, beats_now, beats_inc;
  logic             post_q, post_n, pay_q, pay_n;
  logic             eseen_q, eseen_n;
  logic             gap_q, gap_n;
  logic             acc, end_now, err_any, post_now, pay_now;

  always_comb begin
    acc       = valid_i && ready_i;
    beats_inc = (beats_q == '1) ? beats_q : beats_q + 1'b1;
    beats_now = sop_i ? CNT_W'(1) : beats_inc;
    post_now  = sop_i ? posted_i  : post_q;
    pay_now   = sop_i ? payload_i : pay_q;
    err_any   = (sop_i ? 1'b0 : eseen_q) | (valid_i && err_i);
    end_now   = acc && eop_i && (sop_i || in_pkt_q);

    v_frame_o  = acc && ((sop_i && in_pkt_q) || (eop_i && !sop_i && !in_pkt_q));
    v_erruse_o = end_now && err_any &&
                 (!post_now || !pay_now || (beats_now <= SHORT_MAX));
    v_gap_o    = gap_q && valid_i && sop_i;

    in_pkt_n = in_pkt_q;
    beats_n  = beats_q;
    post_n   = post_q;
    pay_n    = pay_q;
    eseen_n  = eseen_q;
    if (acc && sop_i) begin
      in_pkt_n = !eop_i;
      beats_n  = eop_i ? '0 : beats_now;
      post_n   = posted_i;
      pay_n    = payload_i;
      eseen_n  = eop_i ? 1'b0 : err_i;
    end else if (acc && in_pkt_q) begin
      in_pkt_n = !eop_i;
      beats_n  = eop_i ? '0 : beats_now;
      eseen_n  = eop_i ? 1'b0 : (eseen_q | err_i);
    end else if (in_pkt_q && valid_i && err_i) begin
      eseen_n  = 1'b1;
    end
    gap_n = end_now && err_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      beats_q  <= '0;
      post_q   <= 1'b0;
      pay_q    <= 1'b0;
      eseen_q  <= 1'b0;
      gap_q    <= 1'b0;
    end else begin
      in_pkt_q <= in_pkt_n;
      beats_q  <= beats_n;
      post_q   <= post_n;
      pay_q    <= pay_n;
      eseen_q  <= eseen_n;
      gap_q    <= gap_n;
    end
  end

  assign in_pkt_o = in_pkt_q;

  assert_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_pkt_q) |-> $past(valid_i && ready_i && sop_i));
  assert_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_pkt_q |-> (beats_q != '0));
endmodule

// File: rtl/txm_status.sv
`timescale 1ns/1ps
module txm_status #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] viol_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pulse_o,
  output logic [N-1:0] sticky_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic pls_q, pls_n, stk_q, stk_n, stk_en;

    always_comb begin
      pls_n  = viol_i[i];
      stk_en = viol_i[i] || clr_i[i];
      stk_n  = viol_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pls_q <= 1'b0;
        stk_q <= 1'b0;
      end else begin
        pls_q <= pls_n;
        if (stk_en) stk_q <= stk_n;
      end
    end

    assign pulse_o[i]  = pls_q;
    assign sticky_o[i] = stk_q;

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_q && !clr_i[i]) |=> stk_q);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !viol_i[i]) |=> !stk_q);
  end
endmodule

// File: rtl/txs_compliance_mon.sv
`timescale 1ns/1ps
module txs_compliance_mon
  import txm_pkg::*;
#(
  parameter int unsigned RLAT    = 2,
  parameter int unsigned EMPTY_W = 2,
  parameter int unsigned CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ready_i,
  input  logic               valid_i,
  input  logic               sop_i,
  input  logic               eop_i,
  input  logic [EMPTY_W-1:0] empty_i,
  input  logic               err_i,
  input  logic               posted_i,
  input  logic               payload_i,
  input  logic [NCLS-1:0]    clr_i,
  output logic [NCLS-1:0]    pulse_o,
  output logic [NCLS-1:0]    sticky_o
);
  logic [RLAT-1:0] rd_hist;
  logic            valid_d1, err_d1, in_pkt;
  logic            v_erruse, v_gap, v_frame;
  logic            rd_all_hi, rd_all_lo;
  viol_vec_t       viol;

  txm_hist #(.RLAT(RLAT)) u_hist (
    .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .valid_i(valid_i),
    .err_i(err_i), .rd_hist_o(rd_hist), .valid_d1_o(valid_d1),
    .err_d1_o(err_d1)
  );

  txm_frame #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .valid_i(valid_i),
    .sop_i(sop_i), .eop_i(eop_i), .err_i(err_i), .posted_i(posted_i),
    .payload_i(payload_i), .in_pkt_o(in_pkt), .v_erruse_o(v_erruse),
    .v_gap_o(v_gap), .v_frame_o(v_frame)
  );

  always_comb begin
    rd_all_hi = &rd_hist;
    rd_all_lo = ~|rd_hist;
    viol            = '0;
    viol[V_DROP]    = in_pkt && !valid_i && valid_d1 && rd_all_hi;
    viol[V_LATE]    = valid_i && !ready_i && rd_all_lo;
    viol[V_STALL]   = in_pkt && !valid_i && !valid_d1 && ready_i && rd_all_hi;
    viol[V_EMPTY]   = valid_i && !eop_i && (empty_i != '0);
    viol[V_ERRPOS]  = err_i && (!valid_i || sop_i || eop_i || err_d1);
    viol[V_ERRUSE]  = v_erruse;
    viol[V_NULLGAP] = v_gap;
    viol[V_FRAME]   = v_frame;
  end

  txm_status #(.N(NCLS)) u_status (
    .clk(clk), .rst_n(rst_n), .viol_i(viol), .clr_i(clr_i),
    .pulse_o(pulse_o), .sticky_o(sticky_o)
  );

  assert_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !eop_i && (empty_i != '0)) |=> pulse_o[V_EMPTY]);
  assert_errpos_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_i && !valid_i) |=> pulse_o[V_ERRPOS]);
  assert_late_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !ready_i && rd_all_lo) |=> sticky_o[V_LATE]);
  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (viol == '0) |=> (pulse_o == '0));
endmodule

// File: tb/tb_txs_compliance_mon.sv
`timescale 1ns/1ps
module tb_txs_compliance_mon;
  logic       clk, rst_n;
  logic       ready, valid, sop, eop, err, posted, payload;
  logic [1:0] empty;
  logic [7:0] clr, pulse, sticky;

  localparam logic [7:0] M_DROP  = 8'h01, M_LATE  = 8'h02, M_STALL = 8'h04,
                         M_EMPTY = 8'h08, M_EPOS  = 8'h10, M_EUSE  = 8'h20,
                         M_GAP   = 8'h40, M_FRAME = 8'h80;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_sticky;
  bit done = 0;

  txs_compliance_mon dut (
    .clk(clk), .rst_n(rst_n), .ready_i(ready), .valid_i(valid),
    .sop_i(sop), .eop_i(eop), .empty_i(empty), .err_i(err),
    .posted_i(posted), .payload_i(payload), .clr_i(clr),
    .pulse_o(pulse), .sticky_o(sticky)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, v, s, e, input logic [1:0] emp,
                      input logic er, po, pa, input logic [7:0] exp,
                      input string tag);
    @(negedge clk);
    ready = r; valid = v; sop = s; eop = e; empty = emp;
    err = er; posted = po; payload = pa;
    @(posedge clk);
    #1;
    chk({tag, " pulse"}, pulse, exp);
    exp_sticky = (exp_sticky & ~clr) | exp;
    chk({tag, " sticky R10"}, sticky, exp_sticky);
    clr = '0;
  endtask

  task automatic idle(input string tag);
    step(1, 0, 0, 0, 2'd0, 0, 0, 0, 8'h00, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ready = 1; valid = 0; sop = 0; eop = 0; empty = 0;
    err = 0; posted = 0; payload = 0; clr = '0; exp_sticky = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pulse", pulse, 8'h00);
    chk("R1 reset sticky", sticky, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    idle("R1 after reset");

    // legal 4-beat posted packet with a mid error strobe (nullified)
    step(1,1,1,0,0,0,1,1, 8'h00, "R7 legal sop");
    step(1,1,0,0,0,1,1,1, 8'h00, "R6 legal mid err");
    step(1,1,0,0,0,0,1,1, 8'h00, "R6 legal mid");
    step(1,1,0,1,2'd3,0,1,1, 8'h00, "R5 eop empty ok");
    idle("R8 gap idle");
    step(1,1,1,0,0,0,1,1, 8'h00, "R8 late start ok");
    step(1,1,0,1,0,0,1,1, 8'h00, "R8 close");

    // empty on a non-end beat
    step(1,1,1,0,0,0,1,1, 8'h00, "R5 sop");
    step(1,1,0,0,2'd2,0,1,1, M_EMPTY, "R5 mid empty");
    step(1,1,0,1,2'd1,0,1,1, 8'h00, "R5 eop");
    step(1,0,0,0,2'd3,0,0,0, 8'h00, "R5 idle empty");

    // error placement
    step(1,0,0,0,0,1,0,0, M_EPOS, "R6 err no valid");
    idle("R6 idle");
    step(1,1,1,0,0,0,1,1, 8'h00, "R6 sop");
    step(1,1,0,0,0,1,1,1, 8'h00, "R6 mid err1");
    step(1,1,0,0,0,1,1,1, M_EPOS, "R6 mid err2");
    step(1,1,0,1,0,0,1,1, 8'h00, "R6 eop");
    idle("R6 idle2");
    step(1,1,1,0,0,1,1,1, M_EPOS, "R6 err on sop");
    step(1,1,0,1,0,0,1,1, M_EUSE, "R7 2-beat nullified");
    idle("R7 idle");

    // error use
    step(1,1,1,0,0,0,0,1, 8'h00, "R7 np sop");
    step(1,1,0,0,0,1,0,1, 8'h00, "R7 np mid err");
    step(1,1,0,1,0,0,0,1, M_EUSE, "R7 np eop");
    idle("R7 idle2");
    step(1,1,1,0,0,0,1,0, 8'h00, "R7 nopay sop");
    step(1,1,0,0,0,1,1,0, 8'h00, "R7 nopay err");
    step(1,1,0,1,0,0,1,0, M_EUSE, "R7 nopay eop");
    idle("R7 idle3");
    step(1,1,1,1,0,1,1,1, M_EPOS | M_EUSE, "R7 1-beat err");
    idle("R7 idle4");

    // gap after nullified packet
    step(1,1,1,0,0,0,1,1, 8'h00, "R8 sop");
    step(1,1,0,0,0,1,1,1, 8'h00, "R8 err");
    step(1,1,0,0,0,0,1,1, 8'h00, "R8 mid");
    step(1,1,0,1,0,0,1,1, 8'h00, "R8 eop");
    step(1,1,1,0,0,0,1,1, M_GAP, "R8 back-to-back start");
    step(1,1,0,1,0,0,1,1, 8'h00, "R8 close2");
    idle("R8 idle");

    // framing
    step(1,1,1,0,0,0,1,1, 8'h00, "R9 sop");
    step(1,1,1,0,0,0,1,1, M_FRAME, "R9 sop in packet");
    step(1,1,0,1,0,0,1,1, 8'h00, "R9 eop");
    step(1,1,0,1,0,0,1,1, M_FRAME, "R9 eop no packet");
    step(0,1,0,1,0,0,1,1, 8'h00, "R9 eop not accepted");
    idle("R9 idle");

    // clear, and set wins over clear
    clr = 8'hFF;
    idle("R10 clear all");
    step(1,1,1,0,0,0,1,1, 8'h00, "R10 sop");
    clr = M_EMPTY;
    step(1,1,0,0,2'd1,0,1,1, M_EMPTY, "R10 set over clear");
    step(1,1,0,1,0,0,1,1, 8'h00, "R10 eop");
    clr = M_EMPTY;
    idle("R10 clear one");

    // backpressure sweep: fall delay d, reassert delay e
    for (int d = 0; d < 5; d++) begin
      for (int e = 0; e < 5; e++) begin
        logic [7:0] x;
        step(1,1,1,0,0,0,1,1, 8'h00, "R2 sweep sop");
        step(1,1,0,0,0,0,1,1, 8'h00, "R2 sweep mid");
        for (int k = 0; k < 5; k++) begin
          x = 8'h00;
          if (k == 0 && d == 0) x = M_DROP;
          if (k < d && k >= 2) x = M_LATE;
          step(0, (k < d), 0,0,0,0,1,1, x,
               (x == M_DROP) ? "R2 drop" : "R3 late window");
        end
        for (int j = 0; j <= e; j++) begin
          x = (j >= 2 && j < e) ? M_STALL : 8'h00;
          step(1, (j >= e), 0,0,0,0,1,1, x, "R4 reassert window");
        end
        step(1,1,0,1,0,0,1,1, 8'h00, "R4 sweep eop");
        idle("R2 sweep idle");
      end
    end

    // late stop outside a packet
    step(0,1,1,0,0,0,1,1, 8'h00, "R3 idle hold 0");
    step(0,1,1,0,0,0,1,1, 8'h00, "R3 idle hold 1");
    step(0,1,1,0,0,0,1,1, M_LATE, "R3 idle hold 2");
    step(1,1,1,1,0,0,1,1, 8'h00, "R3 accept");
    idle("R3 idle");

    // reset mid-run clears everything
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R1 async reset pulse", pulse, 8'h00);
    chk("R1 async reset sticky", sticky, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    exp_sticky = '0;
    step(1,1,0,1,0,0,1,1, M_FRAME, "R1 idle after reset");

    finish_run();
  end
endmodule